// File: doc/BRIEF.md
# Periodic Reference-Spur Pattern Canceller

This block sits in the digital back end of a phase detector that samples the reference waveform four times per reference period. Mismatches in that sampling path leave a deterministic error that repeats every four samples and shows up as reference spurs. The block cancels it in two places.

Before the shared compensation DAC, the block builds a correction from three fixed sign patterns. Each pattern describes one kind of mismatch and has its own signed gain. The weighted sum is added to the fractional compensation code and saturated to the DAC range. After the ADC, the block runs a four-sample moving average over the 6-bit phase error. That average removes whatever four-periodic, zero-sum error the DAC correction leaves behind. A bypass input passes the raw ADC sample through instead.

The averager's warm-up is a two-state machine. `AVG_FILL` is entered at reset and counts accepted samples. The transition `FILL_DONE` to `AVG_RUN` is taken on the fourth sample. `AVG_RUN` holds until reset. All work happens on cycles where `smp_vld` is high.

Top module: `spur_pattern_canceller`

## Requirements
- R1: While `rst_n` is low and in the cycle after it rises, `dac_code` is 0, `pe_out` is 0 and `pe_vld` is 0. The averager is in `AVG_FILL` with an empty window.
- R2: One cycle after a cycle with `smp_vld` high, `dac_code` equals `frac_code + s_o*gain_ofs + s_e*gain_edge + s_p*gain_phs`, with all values in two's complement. The signs follow `state_idx`. For index 0,1,2,3 they are: s_o = +1,+1,-1,-1; s_e = +1,-1,-1,+1; s_p = -1,+1,-1,+1.
- R3: When the sum in R2 is above 255, `dac_code` is 255. When it is below -256, `dac_code` is -256.
- R4: `dac_code` does not change in any cycle that follows a cycle with `smp_vld` low.
- R5: With `avg_bypass` low, `pe_out` takes a new value one cycle after each sample. That value is the sum of that sample and the three samples before it, shifted right arithmetically by 2 (rounding toward minus infinity).
- R6: `pe_vld` is a one-cycle pulse one cycle after a sample. With `avg_bypass` low, it stays low for the first three samples after reset and is high for the fourth and every later sample.
- R7: With `avg_bypass` high, `pe_out` one cycle after a sample equals the raw `adc_code`, and `pe_vld` is high for that sample even during warm-up. Bypassed samples still enter the window.
- R8: Once the window is full, an ADC sequence of constant c plus any multiple of one of the three R2 patterns yields `pe_out` = c on every sample.
- R9: `pe_out` holds, and `pe_vld` stays low, in any cycle that follows a cycle with `smp_vld` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | One oversampling sample is present this cycle |
| state_idx | input | 2 | Sampling state 0..3 within the reference period |
| gain_ofs | input | 6 | Signed gain of the differential-offset pattern |
| gain_edge | input | 6 | Signed gain of the unbalanced-edge pattern |
| gain_phs | input | 6 | Signed gain of the phase-mismatch pattern |
| frac_code | input | 9 | Signed fractional compensation code |
| adc_code | input | 6 | Signed digitized phase error |
| avg_bypass | input | 1 | 1 selects the raw sample, 0 the moving average |
| dac_code | output | 9 | Saturated combined DAC code |
| pe_out | output | 6 | Filtered or raw phase error |
| pe_vld | output | 1 | `pe_out` is valid this cycle |

## Verification
The DAC correction and the averaged phase error are both updated by the same sample strobe. Every sample therefore checks both outputs together, one cycle after the strobe. The saturating sums are driven on the fourth sample after reset, so the saturation cases and the `FILL_DONE` transition can fall on the same edge. Samples are separated by idle cycles, and the hold checks sit in those gaps. A strobe that leaked into either path would show up there.

// File: rtl/spur_cancel_pkg.sv
package spur_cancel_pkg;

    typedef enum logic [0:0] {
        AVG_FILL = 1'b0,
        AVG_RUN  = 1'b1
    } avg_state_e;

    // Bit i set means the pattern is -1 at state index i.
    localparam logic [3:0] OFS_NEG  = 4'b1100;
    localparam logic [3:0] EDGE_NEG = 4'b0110;
    localparam logic [3:0] PHS_NEG  = 4'b0101;

    localparam int N_PAT = 3;

    function automatic logic pat_is_neg(input int kind, input logic [1:0] idx);
        logic r;
        unique case (kind)
            0:       r = OFS_NEG[idx];
            1:       r = EDGE_NEG[idx];
            default: r = PHS_NEG[idx];
        endcase
        return r;
    endfunction

endpackage

// File: rtl/spur_corr_sum.sv
module spur_corr_sum
    import spur_cancel_pkg::*;
#(
    parameter int GAIN_W = 6,
    parameter int DAC_W  = 9
) (
    input  logic [1:0]               idx,
    input  logic signed [GAIN_W-1:0] gains [N_PAT],
    input  logic signed [DAC_W-1:0]  frac,
    output logic signed [DAC_W-1:0]  code_sat
);
    localparam int BASE_W = (DAC_W > GAIN_W + 2) ? DAC_W : GAIN_W + 2;
    localparam int SUM_W  = BASE_W + 2;
    localparam logic signed [SUM_W-1:0] HI = SUM_W'((2 ** (DAC_W - 1)) - 1);
    localparam logic signed [SUM_W-1:0] LO = -HI - SUM_W'(1);

    logic signed [SUM_W-1:0] term [N_PAT];
    logic signed [SUM_W-1:0] total;

    generate
        for (genvar k = 0; k < N_PAT; k++) begin : g_term
            logic signed [SUM_W-1:0] g_ext;
            assign g_ext   = $signed({{(SUM_W-GAIN_W){gains[k][GAIN_W-1]}}, gains[k]});
            assign term[k] = pat_is_neg(k, idx) ? -g_ext : g_ext;
        end
    endgenerate

    always_comb begin
        total = $signed({{(SUM_W-DAC_W){frac[DAC_W-1]}}, frac});
        for (int k = 0; k < N_PAT; k++) total = total + term[k];
        if (total > HI)      code_sat = HI[DAC_W-1:0];
        else if (total < LO) code_sat = LO[DAC_W-1:0];
        else                 code_sat = total[DAC_W-1:0];
    end

endmodule

// File: rtl/pe_mavg.sv
module pe_mavg
    import spur_cancel_pkg::*;
#(
    parameter int SMP_W = 6,
    parameter int TAPS  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_vld,
    input  logic signed [SMP_W-1:0] smp,
    input  logic                    bypass,
    output logic signed [SMP_W-1:0] pe_out,
    output logic                    pe_vld
);
    localparam int SH    = $clog2(TAPS);
    localparam int CNT_W = (SH < 1) ? 1 : SH;
    localparam int ACC_W = SMP_W + SH;

    avg_state_e st, st_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic signed [SMP_W-1:0] win [TAPS-1];
    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] avg;
    logic                    last_fill;

    assign last_fill = (st == AVG_FILL) && (cnt == CNT_W'(TAPS - 1));

    always_comb begin
        st_nxt  = st;
        cnt_nxt = cnt;
        unique case (st)
            AVG_FILL: if (smp_vld) begin
                if (last_fill) st_nxt = AVG_RUN;          // FILL_DONE
                else           cnt_nxt = cnt + CNT_W'(1);
            end
            AVG_RUN: st_nxt = AVG_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= AVG_FILL;
            cnt <= '0;
        end else begin
            st  <= st_nxt;
            cnt <= cnt_nxt;
        end
    end

    always_comb begin
        acc = $signed({{SH{smp[SMP_W-1]}}, smp});
        for (int i = 0; i < TAPS - 1; i++)
            acc = acc + $signed({{SH{win[i][SMP_W-1]}}, win[i]});
        avg = acc >>> SH;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TAPS - 1; i++) win[i] <= '0;
            pe_out <= '0;
            pe_vld <= 1'b0;
        end else begin
            pe_vld <= smp_vld && (bypass || st == AVG_RUN || last_fill);
            if (smp_vld) begin
                win[0] <= smp;
                for (int i = 1; i < TAPS - 1; i++) win[i] <= win[i-1];
                pe_out <= bypass ? smp : avg[SMP_W-1:0];
            end
        end
    end

    assert_run_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st == AVG_RUN |=> st == AVG_RUN);
    assert_vld_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pe_vld |-> $past(smp_vld));
    assert_pe_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(smp_vld) |-> ($stable(pe_out) && !pe_vld));
    assert_bypass_raw_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pe_vld && $past(bypass)) |-> pe_out == $past(smp));

endmodule

// File: rtl/spur_pattern_canceller.sv
module spur_pattern_canceller
    import spur_cancel_pkg::*;
#(
    parameter int GAIN_W = 6,
    parameter int DAC_W  = 9,
    parameter int ADC_W  = 6,
    parameter int TAPS   = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_vld,
    input  logic [1:0]              state_idx,
    input  logic signed [GAIN_W-1:0] gain_ofs,
    input  logic signed [GAIN_W-1:0] gain_edge,
    input  logic signed [GAIN_W-1:0] gain_phs,
    input  logic signed [DAC_W-1:0]  frac_code,
    input  logic signed [ADC_W-1:0]  adc_code,
    input  logic                    avg_bypass,
    output logic signed [DAC_W-1:0]  dac_code,
    output logic signed [ADC_W-1:0]  pe_out,
    output logic                    pe_vld
);
    logic signed [GAIN_W-1:0] gain_vec [N_PAT];
    logic signed [DAC_W-1:0]  corr_code;

    assign gain_vec[0] = gain_ofs;
    assign gain_vec[1] = gain_edge;
    assign gain_vec[2] = gain_phs;

    spur_corr_sum #(.GAIN_W(GAIN_W), .DAC_W(DAC_W)) u_corr (
        .idx      (state_idx),
        .gains    (gain_vec),
        .frac     (frac_code),
        .code_sat (corr_code)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)       dac_code <= '0;
        else if (smp_vld) dac_code <= corr_code;
    end

    pe_mavg #(.SMP_W(ADC_W), .TAPS(TAPS)) u_mavg (
        .clk     (clk),
        .rst_n   (rst_n),
        .smp_vld (smp_vld),
        .smp     (adc_code),
        .bypass  (avg_bypass),
        .pe_out  (pe_out),
        .pe_vld  (pe_vld)
    );

    assert_dac_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(smp_vld) |-> $stable(dac_code));

endmodule

// File: tb/spur_pattern_canceller_bench.sv
module spur_pattern_canceller_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_vld = 1'b0;
    logic [1:0] state_idx = '0;
    logic signed [5:0] gain_ofs = '0, gain_edge = '0, gain_phs = '0;
    logic signed [8:0] frac_code = '0;
    logic signed [5:0] adc_code = '0;
    logic avg_bypass = 1'b0;
    logic signed [8:0] dac_code;
    logic signed [5:0] pe_out;
    logic pe_vld;

    int n_chk = 0, n_bad = 0;
    int hist [4] = '{0, 0, 0, 0};
    int nsamp = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    spur_pattern_canceller u_spur_pattern_canceller (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .state_idx(state_idx),
        .gain_ofs(gain_ofs), .gain_edge(gain_edge), .gain_phs(gain_phs),
        .frac_code(frac_code), .adc_code(adc_code), .avg_bypass(avg_bypass),
        .dac_code(dac_code), .pe_out(pe_out), .pe_vld(pe_vld));

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int psign(input int kind, input int idx);
        int o [4] = '{1, 1, -1, -1};
        int e [4] = '{1, -1, -1, 1};
        int p [4] = '{-1, 1, -1, 1};
        if (kind == 0) return o[idx];
        if (kind == 1) return e[idx];
        return p[idx];
    endfunction

    task automatic set_cfg(input int go, input int ge, input int gp, input int fr);
        gain_ofs = 6'(go); gain_edge = 6'(ge); gain_phs = 6'(gp); frac_code = 9'(fr);
    endtask

    // one sample; both outputs checked one cycle after the strobe
    task automatic do_sample(input int idx, input int adc, input string dreq);
        int exp_dac, s, exp_pe;
        bit exp_v;
        @(negedge clk);
        smp_vld = 1'b1; state_idx = 2'(idx); adc_code = 6'(adc);
        exp_dac = int'(frac_code) + psign(0, idx) * int'(gain_ofs)
                + psign(1, idx) * int'(gain_edge) + psign(2, idx) * int'(gain_phs);
        if (exp_dac > 255) exp_dac = 255;
        if (exp_dac < -256) exp_dac = -256;
        for (int i = 3; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = adc;
        nsamp++;
        s = hist[0] + hist[1] + hist[2] + hist[3];
        exp_pe = avg_bypass ? adc : (s >>> 2);
        exp_v = avg_bypass || nsamp >= 4;
        @(posedge clk); #1;
        chk(dreq, "dac_code", int'(dac_code), exp_dac);
        chk("R6", "pe_vld", int'(pe_vld), int'(exp_v));
        if (exp_v) chk(avg_bypass ? "R7" : "R5", "pe_out", int'(pe_out), exp_pe);
        @(negedge clk);
        smp_vld = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "dac_code in reset", int'(dac_code), 0);
        chk("R1", "pe_out in reset", int'(pe_out), 0);
        chk("R1", "pe_vld in reset", int'(pe_vld), 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1", "dac_code after reset", int'(dac_code), 0);
        chk("R1", "pe_vld after reset", int'(pe_vld), 0);
    endtask

    task automatic t_fill_and_sat;
        // R6 warm-up; R3 saturation falls on the FILL_DONE sample
        set_cfg(0, 0, 0, 0);
        do_sample(0, 4, "R2");
        do_sample(1, 8, "R2");
        set_cfg(-32, -32, -32, 200);
        do_sample(2, -12, "R3");
        chk("R6", "no valid before fourth sample", int'(pe_vld), 0);
        set_cfg(31, 31, 31, -256);
        do_sample(2, 20, "R3");
        chk("R5", "first average", int'(pe_out), 5);
        set_cfg(0, 0, 0, 255);
        do_sample(3, 0, "R3");
        set_cfg(0, 0, 0, -256);
        do_sample(3, 0, "R3");
    endtask

    task automatic t_floor;
        set_cfg(0, 0, 0, 0);
        do_sample(0, -1, "R2");
        do_sample(1, 0, "R2");
        do_sample(2, 0, "R2");
        do_sample(3, 0, "R2");
        chk("R5", "floor of -1/4", int'(pe_out), -1);
        do_sample(0, -32, "R2");
        do_sample(1, -32, "R2");
        do_sample(2, -32, "R2");
        do_sample(3, -32, "R2");
        chk("R5", "most negative average", int'(pe_out), -32);
    endtask

    task automatic t_patterns;
        for (int k = 0; k < 3; k++) begin
            for (int i = 0; i < 4; i++) begin
                set_cfg(k == 0 ? 11 : 0, k == 1 ? -7 : 0, k == 2 ? 19 : 0, 0);
                do_sample(i, 0, "R2");
            end
        end
        set_cfg(9, -4, 13, -17);
        for (int i = 0; i < 4; i++) do_sample(i, 2, "R2");
    endtask

    task automatic t_zero_sum;
        set_cfg(0, 0, 0, 0);
        for (int k = 0; k < 3; k++) begin
            for (int r = 0; r < 2; r++)
                for (int i = 0; i < 4; i++) do_sample(i, 3 + 7 * psign(k, i), "R2");
            chk("R8", "pattern cancelled", int'(pe_out), 3);
        end
    endtask

    task automatic t_hold;
        int d0, p0;
        set_cfg(5, 5, 5, 100);
        do_sample(1, 9, "R2");
        d0 = int'(dac_code); p0 = int'(pe_out);
        set_cfg(-20, 30, -8, -200);
        state_idx = 2'd3; adc_code = 6'(-25);
        repeat (5) @(posedge clk);
        #1;
        chk("R4", "dac_code held", int'(dac_code), d0);
        chk("R9", "pe_out held", int'(pe_out), p0);
        chk("R9", "pe_vld low without strobe", int'(pe_vld), 0);
    endtask

    task automatic t_bypass;
        set_cfg(0, 0, 0, 0);
        avg_bypass = 1'b1;
        do_sample(0, 17, "R2");
        do_sample(1, -32, "R2");
        do_sample(2, 31, "R2");
        chk("R7", "raw max passed", int'(pe_out), 31);
        avg_bypass = 1'b0;
        do_sample(3, 0, "R2");   // window now holds bypassed samples
    endtask

    task automatic t_bypass_warmup;
        t_reset();
        nsamp = 0; hist = '{0, 0, 0, 0};
        avg_bypass = 1'b1;
        do_sample(0, -9, "R2");
        chk("R7", "valid during warm-up", int'(pe_vld), 1);
        avg_bypass = 1'b0;
        do_sample(1, 6, "R2");
        chk("R6", "averaged not yet valid", int'(pe_vld), 0);
    endtask

    initial begin
        t_reset();
        t_fill_and_sat();
        t_floor();
        t_patterns();
        t_zero_sum();
        t_hold();
        t_bypass();
        t_bypass_warmup();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule